// File: doc/BRIEF.md
# Unpacked-to-Single Floating-Point Packer

This block takes a floating-point value that an arithmetic unit has left in unpacked form and turns it into a 32-bit IEEE-754 single-precision word. The unpacked form has four parts: a class code, a sign, an unbiased two's-complement exponent, and a 27-bit mantissa. The mantissa holds the explicit leading one and 23 fraction bits, followed by guard, round and sticky bits. The block applies the rounding mode it is given. It deals with both ends of the exponent range: a result too small to be normal is denormalised and then rounded, and a result too large overflows to infinity or to the largest finite value.

Each input is accepted when `in_valid` is high. The packed word and its three status flags (overflow, underflow, inexact) appear in registers one clock later. Between accepted inputs the outputs keep their last value. An underflow-trap-enable input changes when a subnormal result is reported as underflow.

Top module: `fp_single_packer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `out_valid`, `out_word` and all three flags are 0.
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. When `in_valid` is low, `out_word` and the flags keep their previous values.
- R3: Class 0 (zero), and the unused codes 5 to 7, pack as the sign bit followed by 31 zero bits. Class 2 (infinity) packs as the sign, exponent field 255 and fraction 0. Neither sets a flag.
- R4: Class 3 (quiet NaN) and class 4 (signalling NaN) pack as the sign, exponent field 255 and fraction `in_mant[25:3]`, with fraction bit 22 forced to 1. No flag is set.
- R5: For class 1 with a biased exponent (`in_exp`+127) of 1 or more, the significand `in_mant[26:3]` is rounded. The discarded bits are guard `in_mant[2]` and round-or-sticky `in_mant[1]|in_mant[0]`. The mode is selected by `rnd_mode`: 0 is nearest with ties to even, 1 is toward zero, 2 is toward +infinity, 3 is toward -infinity.
- R6: When rounding carries the significand to 2.0, the exponent field is one higher than the biased exponent and the fraction is 0.
- R7: If the final biased exponent is 255 or more, the result overflows. It goes to infinity in mode 0, in mode 2 when positive and in mode 3 when negative; otherwise it goes to exponent 254 with an all-ones fraction. `flag_ovf` is set only when the result is infinity.
- R8: For class 1 with a biased exponent of 0 or less, the significand is shifted right by 1 minus the biased exponent. Bits shifted out feed the sticky bit. The result is then rounded by the rules of R5 and packed with exponent field 0.
- R9: If that rounding produces exactly 1<<23, the result is the smallest normal (exponent field 1, fraction 0) and `flag_unf` stays 0.
- R10: `flag_unf` is set when a subnormal-path result stays subnormal and is either inexact or `unf_trap_en` is high.
- R11: `flag_inx` is set for class 1 whenever any discarded bit is nonzero or the value overflows, and is otherwise 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the input value this cycle |
| in_class | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Sign, 1 = negative |
| in_exp | input | EXP_W (10) | Unbiased exponent, two's complement |
| in_mant | input | 27 | Significand [26:3], guard [2], round [1], sticky [0] |
| rnd_mode | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| unf_trap_en | input | 1 | Underflow trap enable; reports exact subnormals as underflow |
| out_valid | output | 1 | Packed result valid |
| out_word | output | 32 | IEEE-754 single-precision word |
| flag_ovf | output | 1 | Overflow to infinity |
| flag_unf | output | 1 | Underflow |
| flag_inx | output | 1 | Inexact |

## Verification
The assertions check the following on every cycle: the valid timing and hold behaviour, that an overflow flag always comes with an infinite word, that an underflow flag only comes with a zero exponent field, and that every NaN leaves with its quiet bit set. Whether the rounding direction is correct for each mode and sign can only be shown by the bench's scenarios, which compare exact words. The same holds for tie-breaking to even, the carry into the exponent, the choice between infinity and the largest finite value on overflow, and the promotion of the largest subnormal to the smallest normal.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int SGL_FRAC_W = 23;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_BIAS   = 127;
  localparam int SGL_EXP_MAX = (1 << SGL_EXP_W) - 1;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } cls_e;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_ZERO = 2'd1,
    RND_UP   = 2'd2,
    RND_DOWN = 2'd3
  } rnd_e;
endpackage

// File: rtl/fsp_rshift.sv
module fsp_rshift #(
  parameter int W     = 26,
  parameter int AMT_W = 5
) (
  input  logic [W-1:0]     din,
  input  logic [AMT_W-1:0] amt,
  output logic [W-1:0]     dout,
  output logic             lost
);
  logic [W-1:0] drop_mask;

  always_comb begin
    dout      = din >> amt;
    drop_mask = ~({W{1'b1}} << amt);
    lost      = |(din & drop_mask);
  end
endmodule

// File: rtl/fsp_round.sv
module fsp_round import fsp_pkg::*; #(
  parameter int W = 24
) (
  input  logic [W-1:0] kept,
  input  logic         guard,
  input  logic         rs,
  input  logic         sign,
  input  logic [1:0]   mode,
  output logic [W:0]   sum,
  output logic         inexact
);
  logic bump;

  always_comb begin
    inexact = guard | rs;
    unique case (rnd_e'(mode))
      RND_NEAR: bump = guard & (rs | kept[0]);
      RND_ZERO: bump = 1'b0;
      RND_UP:   bump = inexact & ~sign;
      default:  bump = inexact & sign;
    endcase
    sum = {1'b0, kept} + {{W{1'b0}}, bump};
  end
endmodule

// File: rtl/fsp_ovf_sel.sv
module fsp_ovf_sel import fsp_pkg::*; (
  input  logic       sign,
  input  logic [1:0] mode,
  output logic       to_inf
);
  always_comb begin
    unique case (rnd_e'(mode))
      RND_NEAR: to_inf = 1'b1;
      RND_ZERO: to_inf = 1'b0;
      RND_UP:   to_inf = ~sign;
      default:  to_inf = sign;
    endcase
  end
endmodule

// File: rtl/fp_single_packer.sv
module fp_single_packer import fsp_pkg::*; #(
  parameter int EXP_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [2:0]              in_class,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [26:0]             in_mant,
  input  logic [1:0]              rnd_mode,
  input  logic                    unf_trap_en,
  output logic                    out_valid,
  output logic [31:0]             out_word,
  output logic                    flag_ovf,
  output logic                    flag_unf,
  output logic                    flag_inx
);
  localparam int SIG_W  = SGL_FRAC_W + 1;
  localparam int MANT_W = SIG_W + 3;
  localparam int SH_W   = MANT_W - 1;
  localparam int AMT_W  = $clog2(SH_W + 1);
  localparam int BEXP_W = EXP_W + 2;

  // biased exponent and path select
  logic signed [BEXP_W-1:0] bexp;
  logic signed [BEXP_W-1:0] exp_n;
  logic [BEXP_W-1:0]        sh_raw;
  logic [AMT_W-1:0]         sh_amt;
  logic                     is_sub;

  always_comb begin
    bexp   = {{2{in_exp[EXP_W-1]}}, in_exp} + BEXP_W'(SGL_BIAS);
    is_sub = bexp[BEXP_W-1] | (bexp == '0);
    sh_raw = BEXP_W'(1) - bexp;
    sh_amt = (sh_raw >= BEXP_W'(SH_W)) ? AMT_W'(SH_W) : sh_raw[AMT_W-1:0];
  end

  // denormalising shift, sticky collected
  logic [SH_W-1:0] sh_out;
  logic            sh_lost;

  fsp_rshift #(.W(SH_W), .AMT_W(AMT_W)) u_shift (
    .din  (in_mant[MANT_W-1:1]),
    .amt  (sh_amt),
    .dout (sh_out),
    .lost (sh_lost)
  );

  // one shared rounder for both paths
  logic [SIG_W-1:0] r_kept;
  logic             r_guard, r_rs;
  logic [SIG_W:0]   r_sum;
  logic             r_inx;

  always_comb begin
    if (is_sub) begin
      r_kept  = sh_out[SH_W-1:2];
      r_guard = sh_out[1];
      r_rs    = sh_out[0] | sh_lost | in_mant[0];
    end else begin
      r_kept  = in_mant[MANT_W-1:3];
      r_guard = in_mant[2];
      r_rs    = in_mant[1] | in_mant[0];
    end
  end

  fsp_round #(.W(SIG_W)) u_round (
    .kept    (r_kept),
    .guard   (r_guard),
    .rs      (r_rs),
    .sign    (in_sign),
    .mode    (rnd_mode),
    .sum     (r_sum),
    .inexact (r_inx)
  );

  logic ovf_inf;

  fsp_ovf_sel u_ovf (
    .sign   (in_sign),
    .mode   (rnd_mode),
    .to_inf (ovf_inf)
  );

  // next-state packing
  logic [31:0] word_d;
  logic        ovf_d, unf_d, inx_d;
  logic        ovf_hit;

  always_comb begin
    exp_n   = bexp + BEXP_W'(r_sum[SIG_W]);
    ovf_hit = exp_n >= $signed(BEXP_W'(SGL_EXP_MAX));
    word_d  = {in_sign, 31'd0};
    ovf_d   = 1'b0;
    unf_d   = 1'b0;
    inx_d   = 1'b0;
    unique case (in_class)
      CLS_INF: word_d = {in_sign, {SGL_EXP_W{1'b1}}, {SGL_FRAC_W{1'b0}}};
      CLS_QNAN, CLS_SNAN:
        word_d = {in_sign, {SGL_EXP_W{1'b1}}, 1'b1, in_mant[MANT_W-3:3]};
      CLS_NUM: begin
        inx_d = r_inx;
        if (is_sub) begin
          word_d = {in_sign, {(SGL_EXP_W-1){1'b0}}, r_sum[SIG_W-1], r_sum[SGL_FRAC_W-1:0]};
          unf_d  = ~r_sum[SIG_W-1] & (r_inx | unf_trap_en);
        end else if (ovf_hit) begin
          inx_d = 1'b1;
          ovf_d = ovf_inf;
          word_d = ovf_inf ? {in_sign, {SGL_EXP_W{1'b1}}, {SGL_FRAC_W{1'b0}}}
                           : {in_sign, SGL_EXP_W'(SGL_EXP_MAX - 1), {SGL_FRAC_W{1'b1}}};
        end else begin
          word_d = {in_sign, exp_n[SGL_EXP_W-1:0], r_sum[SGL_FRAC_W-1:0]};
        end
      end
      default: word_d = {in_sign, 31'd0};
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      flag_ovf  <= 1'b0;
      flag_unf  <= 1'b0;
      flag_inx  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= word_d;
        flag_ovf <= ovf_d;
        flag_unf <= unf_d;
        flag_inx <= inx_d;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word) && $stable(flag_unf));
  a_r7_ovf_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ovf |-> out_word[30:0] == 31'h7F80_0000);
  a_r10_unf_exp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flag_unf |-> out_word[30:23] == 8'd0);
  a_r4_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_word[30:23] == 8'hFF && out_word[22:0] != 23'd0) |-> out_word[22]);
endmodule

// File: tb/tb_fp_single_packer.sv
module tb_fp_single_packer;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [2:0]        in_class;
  logic              in_sign;
  logic signed [9:0] in_exp;
  logic [26:0]       in_mant;
  logic [1:0]        rnd_mode;
  logic              unf_trap_en;
  logic              out_valid;
  logic [31:0]       out_word;
  logic              flag_ovf, flag_unf, flag_inx;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fp_single_packer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .rnd_mode(rnd_mode),
    .unf_trap_en(unf_trap_en), .out_valid(out_valid), .out_word(out_word),
    .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_inx(flag_inx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // flags compared as {ovf,unf,inx}
  task automatic run(input string req, input int cls, input bit s, input int e,
                     input logic [23:0] sig, input logic [2:0] grs, input int mode,
                     input bit trap, input logic [31:0] ew, input logic [2:0] ef);
    @(negedge clk);
    in_valid = 1'b1; in_class = 3'(cls); in_sign = s; in_exp = 10'(e);
    in_mant = {sig, grs}; rnd_mode = 2'(mode); unf_trap_en = trap;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " word"}, out_word, ew);
    chk({req, " flags"}, {29'd0, flag_ovf, flag_unf, flag_inx}, {29'd0, ef});
    chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
  endtask

  task automatic t_reset;
    chk("R1 valid", {31'd0, out_valid}, 32'd0);
    chk("R1 word", out_word, 32'd0);
    chk("R1 flags", {29'd0, flag_ovf, flag_unf, flag_inx}, 32'd0);
  endtask

  task automatic t_hold;
    run("R2 load", 1, 0, 0, 24'h800000, 3'b000, 0, 0, 32'h3F80_0000, 3'b000);
    in_class = 3'd2; in_sign = 1'b1; in_mant = '1;
    @(negedge clk);
    chk("R2 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R2 hold word", out_word, 32'h3F80_0000);
  endtask

  task automatic t_specials;
    run("R3 zero neg", 0, 1, 5, 24'hFFFFFF, 3'b111, 0, 0, 32'h8000_0000, 3'b000);
    run("R3 inf pos", 2, 0, 0, 24'h800000, 3'b000, 0, 0, 32'h7F80_0000, 3'b000);
    run("R3 code6", 6, 0, 3, 24'h800000, 3'b000, 0, 0, 32'h0000_0000, 3'b000);
    run("R4 qnan", 3, 0, 0, 24'hC00000, 3'b000, 0, 0, 32'h7FC0_0000, 3'b000);
    run("R4 snan", 4, 1, 0, 24'h800001, 3'b000, 0, 0, 32'hFFC0_0001, 3'b000);
  endtask

  task automatic t_round_modes;
    run("R5 exact", 1, 0, 0, 24'h800000, 3'b000, 0, 0, 32'h3F80_0000, 3'b000);
    run("R5 tie even down", 1, 0, 0, 24'h800000, 3'b100, 0, 0, 32'h3F80_0000, 3'b001);
    run("R5 tie odd up", 1, 0, 0, 24'h800001, 3'b100, 0, 0, 32'h3F80_0002, 3'b001);
    run("R5 above half", 1, 0, 0, 24'h800000, 3'b101, 0, 0, 32'h3F80_0001, 3'b001);
    run("R5 below half", 1, 0, 0, 24'h800000, 3'b011, 0, 0, 32'h3F80_0000, 3'b001);
    run("R5 toward zero", 1, 0, 0, 24'h800000, 3'b110, 1, 0, 32'h3F80_0000, 3'b001);
    run("R5 up pos", 1, 0, 0, 24'h800000, 3'b001, 2, 0, 32'h3F80_0001, 3'b001);
    run("R5 up neg", 1, 1, 0, 24'h800000, 3'b001, 2, 0, 32'hBF80_0000, 3'b001);
    run("R5 down neg", 1, 1, 0, 24'h800000, 3'b001, 3, 0, 32'hBF80_0001, 3'b001);
    run("R5 down pos", 1, 0, 0, 24'h800000, 3'b001, 3, 0, 32'h3F80_0000, 3'b001);
  endtask

  task automatic t_carry;
    run("R6 carry", 1, 0, 0, 24'hFFFFFF, 3'b100, 0, 0, 32'h4000_0000, 3'b001);
  endtask

  task automatic t_overflow;
    run("R7 max finite", 1, 0, 127, 24'hFFFFFF, 3'b000, 0, 0, 32'h7F7F_FFFF, 3'b000);
    run("R7 near inf", 1, 0, 128, 24'h800000, 3'b000, 0, 0, 32'h7F80_0000, 3'b101);
    run("R7 zero max", 1, 0, 128, 24'h800000, 3'b000, 1, 0, 32'h7F7F_FFFF, 3'b001);
    run("R7 up neg max", 1, 1, 128, 24'h800000, 3'b000, 2, 0, 32'hFF7F_FFFF, 3'b001);
    run("R7 down neg inf", 1, 1, 200, 24'h800000, 3'b000, 3, 0, 32'hFF80_0000, 3'b101);
    run("R7 carry inf", 1, 0, 127, 24'hFFFFFF, 3'b100, 0, 0, 32'h7F80_0000, 3'b101);
  endtask

  task automatic t_subnormal;
    run("R8 half min", 1, 0, -127, 24'h800000, 3'b000, 0, 0, 32'h0040_0000, 3'b000);
    run("R10 trap exact", 1, 0, -127, 24'h800000, 3'b000, 0, 1, 32'h0040_0000, 3'b010);
    run("R8 tiniest", 1, 0, -149, 24'h800000, 3'b000, 0, 0, 32'h0000_0001, 3'b000);
    run("R10 tie to zero", 1, 1, -150, 24'h800000, 3'b000, 0, 0, 32'h8000_0000, 3'b011);
    run("R9 promote", 1, 0, -127, 24'hFFFFFF, 3'b000, 0, 0, 32'h0080_0000, 3'b001);
    run("R9 promote trap", 1, 0, -127, 24'hFFFFFF, 3'b000, 0, 1, 32'h0080_0000, 3'b001);
    run("R10 stay sub", 1, 0, -127, 24'hFFFFFF, 3'b000, 1, 0, 32'h007F_FFFF, 3'b011);
    run("R11 deep sticky", 1, 0, -400, 24'h800000, 3'b000, 2, 0, 32'h0000_0001, 3'b011);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_class = '0; in_sign = 1'b0;
    in_exp = '0; in_mant = '0; rnd_mode = '0; unf_trap_en = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold();
    t_specials();
    t_round_modes();
    t_carry();
    t_overflow();
    t_subnormal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule